// File: doc/BRIEF.md
# Flash Write-Protection Status Logic

This block holds the status register of a serial NOR flash controller and rules on each write-type command before it reaches the array. A command decoder hands it one request at a time: a command class, a target byte address and, for status writes, the new status value. One clock later the block answers with accept or reject. For accepted program and erase requests it also raises a one-cycle execute strobe toward the array sequencer.

Three kinds of state are kept. The write-enable latch is volatile. The three-bit protect field selects a region at the top of a 2 Mbit (256 KiB) array. The status lock bit is one-time programmable: once it is set, the protect field and the lock bit itself can no longer be changed. Protect and lock bits survive a soft reset and clear only on power-on reset.

Sector and block erases are judged on the whole unit they would wipe. Page programs are judged on the whole page. A chip erase is allowed only when the protect field is zero. The status byte is available at all times for status reads, with the live busy input in bit 0.

Top module: `flash_wp_status`

## Requirements
- R1: `status_byte` shows `busy_in` in bit 0, the write-enable latch in bit 1, the protect field in bits 4:2 and the lock bit in bit 7. Bits 6:5 always read 0, even after a status write with data 0xFF.
- R2: `cmd_kind` codes are 0 write-enable, 1 write-disable, 2 status write, 3 page program, 4 sector erase, 5 block erase, 6 chip erase, and 7 undefined. Code 0 sets the write-enable latch and code 1 clears it. Both are accepted whenever `busy_in` is 0.
- R3: While the write-enable latch is 0, codes 2 to 6 are rejected.
- R4: An accepted status write loads the protect field from `cmd_wdata[4:2]` and the lock bit from `cmd_wdata[7]`, and clears the write-enable latch. It is accepted only with the latch at 1 and the lock bit at 0.
- R5: While the lock bit is 1, status writes are rejected, and the protect field and lock bit stay unchanged.
- R6: The protect field selects the protected region. Value 0 protects nothing and value 7 protects the whole array. A value k from 1 to 6 protects the top 1/2^(7-k) of the 256 KiB space, so 1 protects 0x3F000 and up, and 6 protects 0x20000 and up. A page program whose 256-byte page touches the region is rejected.
- R7: A sector erase (4 KiB) or block erase (64 KiB) is rejected if any byte of the aligned unit that contains `cmd_addr` lies in the protected region.
- R8: A chip erase is rejected whenever the protect field is nonzero.
- R9: An accepted page program, sector erase, block erase or chip erase raises `exec_pulse` together with `cmd_accept` and clears the write-enable latch. Codes 0 to 2 never raise `exec_pulse`.
- R10: A rejected command leaves the write-enable latch, protect field and lock bit unchanged.
- R11: While `busy_in` is 1, every command is rejected.
- R12: `rst_n` low clears the write-enable latch and keeps the protect field and lock bit. `por_n` low clears all status bits.
- R13: For each cycle with `cmd_valid` high, exactly one of `cmd_accept` and `cmd_reject` is high for one cycle in the next cycle. With no request, both stay low. Code 7 is always rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Soft reset, active low, clears volatile state only |
| cmd_valid | input | 1 | One-cycle command request |
| cmd_kind | input | 3 | Command class code |
| cmd_addr | input | ADDR_W (18) | Target byte address |
| cmd_wdata | input | 8 | New status value for status writes |
| busy_in | input | 1 | Array busy; may be tied to 0 |
| cmd_accept | output | 1 | Request granted (registered) |
| cmd_reject | output | 1 | Request refused (registered) |
| exec_pulse | output | 1 | Strobe to start a program or erase in the array |
| status_byte | output | 8 | Status value for status reads |

## Verification
The assertions assume that requests come as isolated one-cycle `cmd_valid` pulses and that `cmd_kind`, `cmd_addr`, `cmd_wdata` and `busy_in` are steady around the sampling edge. The stimulus meets this by changing inputs only on falling edges and leaving a full idle cycle between requests. The lock property also assumes that `por_n` is the only way to clear the lock bit, so the bench pulses power-on reset only in its final directed step.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    CMD_WREN   = 3'd0,
    CMD_WRDI   = 3'd1,
    CMD_STATWR = 3'd2,
    CMD_PROG   = 3'd3,
    CMD_SECER  = 3'd4,
    CMD_BLKER  = 3'd5,
    CMD_CHIPER = 3'd6,
    CMD_UNDEF  = 3'd7
  } cmd_kind_e;

  localparam int unsigned PROT_W      = 3;
  localparam int unsigned ST_BUSY     = 0;
  localparam int unsigned ST_WEL      = 1;
  localparam int unsigned ST_PROT_LO  = 2;
  localparam int unsigned ST_LOCK     = 7;

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned PROT_W = 3
) (
  input  logic [PROT_W-1:0] prot,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_region
);

  localparam int unsigned TOP = (1 << PROT_W) - 1;

  logic [TOP:0] hit_by_level;

  assign hit_by_level[0]   = 1'b0;
  assign hit_by_level[TOP] = 1'b1;

  generate
    for (genvar g = 1; g < TOP; g++) begin : g_level
      // level g protects the top 1/2^(TOP-g): all TOP-g upper address bits set
      assign hit_by_level[g] = &addr[ADDR_W-1 -: (TOP - g)];
    end
  endgenerate

  assign in_region = hit_by_level[prot];

endmodule

// File: rtl/wp_cmd_judge.sv
module wp_cmd_judge
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned SECTOR_W = 12,
  parameter int unsigned BLOCK_W  = 16
) (
  input  cmd_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wel,
  input  logic [PROT_W-1:0] prot,
  input  logic              lock,
  input  logic              busy,
  output logic              grant,
  output logic              array_op
);

  localparam logic [ADDR_W-1:0] PAGE_SPAN   = {{(ADDR_W-PAGE_W){1'b0}},   {PAGE_W{1'b1}}};
  localparam logic [ADDR_W-1:0] SECTOR_SPAN = {{(ADDR_W-SECTOR_W){1'b0}}, {SECTOR_W{1'b1}}};
  localparam logic [ADDR_W-1:0] BLOCK_SPAN  = {{(ADDR_W-BLOCK_W){1'b0}},  {BLOCK_W{1'b1}}};

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] unit_end;
  logic              unit_hit;

  always_comb begin
    unique case (kind)
      CMD_PROG:  span = PAGE_SPAN;
      CMD_SECER: span = SECTOR_SPAN;
      CMD_BLKER: span = BLOCK_SPAN;
      default:   span = '0;
    endcase
  end

  // the highest byte of the unit is the one that reaches furthest into the top region
  assign unit_end = addr | span;

  wp_region_decode #(
    .ADDR_W (ADDR_W),
    .PROT_W (PROT_W)
  ) u_region (
    .prot      (prot),
    .addr      (unit_end),
    .in_region (unit_hit)
  );

  always_comb begin
    grant    = 1'b0;
    array_op = 1'b0;
    unique case (kind)
      CMD_WREN, CMD_WRDI: grant = !busy;
      CMD_STATWR:         grant = !busy && wel && !lock;
      CMD_PROG, CMD_SECER, CMD_BLKER: begin
        grant    = !busy && wel && !unit_hit;
        array_op = 1'b1;
      end
      CMD_CHIPER: begin
        grant    = !busy && wel && (prot == '0);
        array_op = 1'b1;
      end
      default:            grant = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned SECTOR_W    = 12,
  parameter int unsigned BLOCK_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              busy_in,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              exec_pulse,
  output logic [7:0]        status_byte
);

  logic por_ok;
  logic soft_ok;
  logic soft_raw_n;

  assign soft_raw_n = rst_n & por_n;

  wp_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_ok)
  );

  wp_rst_sync #(.STAGES(SYNC_STAGES)) u_soft_sync (
    .clk    (clk),
    .arst_n (soft_raw_n),
    .srst_n (soft_ok)
  );

  cmd_kind_e         kind;
  logic              wel_q, wel_d;
  logic [PROT_W-1:0] prot_q, prot_d;
  logic              lock_q, lock_d;
  logic              acc_q, acc_d;
  logic              rej_q, rej_d;
  logic              exec_q, exec_d;
  logic              grant;
  logic              array_op;
  logic              nv_en;
  logic              wel_en;

  assign kind = cmd_kind_e'(cmd_kind);

  wp_cmd_judge #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .SECTOR_W (SECTOR_W),
    .BLOCK_W  (BLOCK_W)
  ) u_judge (
    .kind     (kind),
    .addr     (cmd_addr),
    .wel      (wel_q),
    .prot     (prot_q),
    .lock     (lock_q),
    .busy     (busy_in),
    .grant    (grant),
    .array_op (array_op)
  );

  // clock enables
  assign wel_en = cmd_valid && grant;
  assign nv_en  = cmd_valid && grant && (kind == CMD_STATWR);

  // next state
  always_comb begin
    wel_d  = wel_q;
    prot_d = prot_q;
    lock_d = lock_q;
    acc_d  = cmd_valid && grant;
    rej_d  = cmd_valid && !grant;
    exec_d = cmd_valid && grant && array_op;
    unique case (kind)
      CMD_WREN: wel_d = 1'b1;
      CMD_WRDI: wel_d = 1'b0;
      CMD_STATWR: begin
        wel_d  = 1'b0;
        prot_d = cmd_wdata[ST_PROT_LO +: PROT_W];
        lock_d = cmd_wdata[ST_LOCK];
      end
      default:  wel_d = 1'b0;
    endcase
  end

  // non-volatile bits: cleared by power-on reset only
  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) begin
      prot_q <= '0;
      lock_q <= 1'b0;
    end else if (nv_en) begin
      prot_q <= prot_d;
      lock_q <= lock_d;
    end
  end

  // volatile latch
  always_ff @(posedge clk or negedge soft_ok) begin
    if (!soft_ok) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  // verdict registers
  always_ff @(posedge clk or negedge soft_ok) begin
    if (!soft_ok) begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      exec_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      rej_q  <= rej_d;
      exec_q <= exec_d;
    end
  end

  assign cmd_accept  = acc_q;
  assign cmd_reject  = rej_q;
  assign exec_pulse  = exec_q;
  assign status_byte = {lock_q, 2'b00, prot_q, wel_q, busy_in};

endmodule

// File: rtl/wp_checker.sv
module wp_checker (
  input logic       clk,
  input logic       soft_ok,
  input logic       por_ok,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       busy_in,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       exec_pulse,
  input logic [7:0] status_byte
);

  logic guarded;
  assign guarded = cmd_valid && (cmd_kind >= 3'd2) && (cmd_kind <= 3'd6);

  // R3
  no_wel_no_grant_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    (guarded && !status_byte[1]) |=> !cmd_accept);

  // R5
  lock_freezes_chk: assert property (@(posedge clk) disable iff (!por_ok)
    status_byte[7] |=> (status_byte[7] && $stable(status_byte[4:2])));

  // R8
  chip_erase_guard_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    (cmd_valid && cmd_kind == 3'd6 && status_byte[4:2] != 3'd0) |=> !cmd_accept);

  // R9
  exec_with_accept_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    exec_pulse |-> cmd_accept);

  // R9
  wel_spent_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    guarded |=> (cmd_reject || !status_byte[1]));

  // R10
  reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    cmd_reject |-> $stable(status_byte[7:1]));

  // R11
  busy_refuses_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    (cmd_valid && busy_in) |=> cmd_reject);

  // R13
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    !(cmd_accept && cmd_reject));

  // R13
  verdict_needs_req_chk: assert property (@(posedge clk) disable iff (!soft_ok)
    (cmd_accept || cmd_reject) |-> $past(cmd_valid));

endmodule

bind flash_wp_status wp_checker u_wp_checker (
  .clk         (clk),
  .soft_ok     (soft_ok),
  .por_ok      (por_ok),
  .cmd_valid   (cmd_valid),
  .cmd_kind    (cmd_kind),
  .busy_in     (busy_in),
  .cmd_accept  (cmd_accept),
  .cmd_reject  (cmd_reject),
  .exec_pulse  (exec_pulse),
  .status_byte (status_byte)
);

// File: tb/tb_flash_wp_status.sv
module tb_flash_wp_status;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int NVEC = 37;

  // {kind[3], addr[18], wdata[8], busy[1], exp_acc[1], exp_exec[1], exp_status[8]}
  localparam logic [39:0] VEC [NVEC] = '{
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02}, // R2 set latch
    {3'd1, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R2 clear latch
    {3'd3, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 program
    {3'd2, 18'h00000, 8'h0C, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 status write
    {3'd4, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 sector erase
    {3'd6, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 chip erase
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02},
    {3'd2, 18'h00000, 8'h04, 1'b0, 1'b1, 1'b0, 8'h04}, // R4 prot=1
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h06},
    {3'd3, 18'h3F000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h06}, // R6 R10 top 4 KiB
    {3'd3, 18'h3EFFF, 8'h00, 1'b0, 1'b1, 1'b1, 8'h04}, // R6 R9 just below
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h06},
    {3'd6, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h06}, // R8
    {3'd5, 18'h30000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h06}, // R7 block overlaps
    {3'd4, 18'h3E000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h04}, // R7 sector clear
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h06},
    {3'd2, 18'h00000, 8'h18, 1'b0, 1'b1, 1'b0, 8'h18}, // R4 prot=6
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h1A},
    {3'd3, 18'h20000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1A}, // R6 upper half
    {3'd3, 18'h1FFFF, 8'h00, 1'b0, 1'b1, 1'b1, 8'h18}, // R6 lower half
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h1A},
    {3'd2, 18'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h1A}, // R11
    {3'd0, 18'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h1A}, // R11
    {3'd7, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1A}, // R13 undefined code
    {3'd2, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02},
    {3'd6, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // R8 R9 prot=0
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02},
    {3'd5, 18'h30000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // R7 unprotected
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02},
    {3'd2, 18'h00000, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h9C}, // R1 R4 lock, prot=7
    {3'd0, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h9E},
    {3'd2, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h9E}, // R5
    {3'd3, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h9E}, // R6 whole array
    {3'd4, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h9E}, // R7 whole array
    {3'd1, 18'h00000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h9C}, // R2
    {3'd2, 18'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h9C}  // R5 latch clear too
  };

  logic              clk = 1'b0;
  logic              por_n;
  logic              rst_n;
  logic              cmd_valid;
  logic [2:0]        cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_wdata;
  logic              busy_in;
  logic              cmd_accept;
  logic              cmd_reject;
  logic              exec_pulse;
  logic [7:0]        status_byte;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_status dut (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .busy_in     (busy_in),
    .cmd_accept  (cmd_accept),
    .cmd_reject  (cmd_reject),
    .exec_pulse  (exec_pulse),
    .status_byte (status_byte)
  );

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = '0;
    cmd_addr = '0; cmd_wdata = '0; busy_in = 1'b0;
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    idle(4);

    // R12 R13 reset state
    check("R12 reset status", status_byte, 8'h00);
    check("R13 reset verdicts", {5'd0, cmd_accept, cmd_reject, exec_pulse}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VEC[i];
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_kind  = v[39:37];
      cmd_addr  = v[36:19];
      cmd_wdata = v[18:11];
      busy_in   = v[10];
      @(negedge clk);
      cmd_valid = 1'b0;
      busy_in   = 1'b0;
      #1;
      check($sformatf("vector %0d accept", i), {7'd0, cmd_accept}, {7'd0, v[9]});
      check($sformatf("vector %0d reject", i), {7'd0, cmd_reject}, {7'd0, !v[9]});
      check($sformatf("vector %0d exec", i),   {7'd0, exec_pulse}, {7'd0, v[8]});
      check($sformatf("vector %0d status", i), status_byte, v[7:0]);
    end

    // R13 no request, no verdict
    idle(1);
    #1;
    check("R13 idle verdicts", {5'd0, cmd_accept, cmd_reject, exec_pulse}, 8'h00);

    // R1 busy bit follows input
    busy_in = 1'b1;
    #1;
    check("R1 busy bit", status_byte, 8'h9D);
    busy_in = 1'b0;
    #1;
    check("R1 busy bit low", status_byte, 8'h9C);

    // R12 soft reset keeps non-volatile bits, clears latch
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    check("R12 latch set before soft reset", status_byte, 8'h9E);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    #1;
    check("R12 soft reset", status_byte, 8'h9C);

    // R12 power-on reset clears everything
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(4);
    #1;
    check("R12 power-on reset", status_byte, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule